// File: doc/BRIEF.md
# Page Hamming ECC accumulator

This block sits beside the byte stream of a NAND data path and builds a single-error-correcting Hamming parity word for each fixed-size chunk of page data, whichever way the bytes are moving. Every accepted byte adds to two parts of the word. Column parity tracks the XOR of the bit positions within each byte. Line parity tracks each byte's overall parity, grouped by the bits of the byte's position in the chunk. Software uses the result to correct a single flipped bit. The block does not correct data itself.

When a chunk is complete, the block latches its parity word and raises a one-cycle done pulse that carries the chunk number. It then starts the next chunk from zero. It also presents the result in the 3-byte form that is stored in the spare area. The clear input starts a new page. After a full page of data chunks, later bytes belong to the out-of-band area and are not counted.

Top module: `hecc_chunk_acc`

## Requirements
- R1: During and right after reset, `chunk_done` is 0, `par_raw` is 0, `chunk_num` is 0 and `spare_bytes` is 24'hFFFFFF.
- R2: Bits [5:0] of `par_raw` are column parity. For k in 0..2, bit 2k is the XOR of all data bits whose bit position has bit k equal to 0, and bit 2k+1 is the XOR of those whose position has bit k equal to 1.
- R3: Bits above 5 are line parity. For j in 0..log2(CHUNK_BYTES)-1, bit 6+2j is the XOR of the byte parities of bytes whose index in the chunk has bit j equal to 0, and bit 6+2j+1 is the XOR for those whose index has bit j equal to 1.
- R4: A byte is taken on a rising edge where `byte_vld` and `ecc_en` are both 1. Taking the last byte of a chunk raises `chunk_done` for exactly the next cycle and loads `par_raw` and `chunk_num`. These outputs then hold until the next done pulse.
- R5: The accumulator restarts after every chunk, so back-to-back chunks each report parity over their own bytes only.
- R6: The stored value is S = ~({par_raw, 2'b00}) masked to 24 bits, with the raw word zero-extended. `spare_bytes[7:0]` (spare byte 0) = S[23:16], `spare_bytes[15:8]` (byte 1) = S[15:8], and `spare_bytes[23:16]` (byte 2) = S[7:0].
- R7: While `ecc_en` is 0, valid bytes are ignored. They do not advance the chunk and do not change its parity.
- R8: `ecc_clr` discards any partial chunk and resets the chunk count. It takes priority over a byte in the same cycle and does not alter the last reported result.
- R9: After PAGE_CHUNKS chunks since the last clear, all further bytes are ignored until the next clear, so no more done pulses occur.
- R10: `chunk_num` is the 0-based index of the reported chunk, counted since the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_en | input | 1 | Allows bytes to be accumulated |
| ecc_clr | input | 1 | Starts a new page: clears the partial chunk and the chunk count |
| byte_vld | input | 1 | A data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte |
| chunk_done | output | 1 | One-cycle pulse when a chunk's result is loaded |
| chunk_num | output | log2(PAGE_CHUNKS) | Index of the reported chunk |
| par_raw | output | 6+2*log2(CHUNK_BYTES) | Raw parity word of the last chunk |
| spare_bytes | output | 24 | Stored form, spare byte 0 in the low byte |

## Verification
The bench builds the block with CHUNK_BYTES=16 and PAGE_CHUNKS=4, so the line-parity field is 8 bits wide. With this chunk size, chunk restart, back-to-back chunks and the end of the page are all reached in a few hundred cycles. The 16-byte chunk still exercises every column-parity bit and four index bits. The same logic covers the full 256-byte, 16-chunk default, because all widths are derived from the two parameters.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    localparam int COL_W   = 6;
    localparam int STORE_W = 24;

    // Column parity contribution of one byte
    function automatic logic [COL_W-1:0] col_bits(input logic [7:0] d);
        logic [COL_W-1:0] c;
        c = '0;
        for (int k = 0; k < 3; k++) begin
            for (int b = 0; b < 8; b++) begin
                if (b[k]) c[2*k+1] = c[2*k+1] ^ d[b];
                else      c[2*k]   = c[2*k]   ^ d[b];
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/hecc_line_contrib.sv
module hecc_line_contrib #(
    parameter int IDX_W = 8
) (
    input  logic [7:0]         data,
    input  logic [IDX_W-1:0]   idx,
    output logic [2*IDX_W-1:0] line
);
    logic par;
    assign par = ^data;

    // Each index bit steers the byte parity into the "0" or "1" line bit
    for (genvar j = 0; j < IDX_W; j++) begin : g_line
        assign line[2*j]   = par & ~idx[j];
        assign line[2*j+1] = par &  idx[j];
    end
endmodule

// File: rtl/hecc_spare_pack.sv
module hecc_spare_pack
    import hecc_pkg::*;
#(
    parameter int RAW_W = 22
) (
    input  logic [RAW_W-1:0]   raw,
    output logic [STORE_W-1:0] spare
);
    logic [STORE_W-1:0] shifted;
    logic [STORE_W-1:0] stored;

    assign shifted = STORE_W'({raw, 2'b00});
    assign stored  = ~shifted;
    // spare byte 0 takes the top of the stored value
    assign spare   = {stored[7:0], stored[15:8], stored[23:16]};
endmodule

// File: rtl/hecc_chunk_acc.sv
module hecc_chunk_acc
    import hecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 256,
    parameter int PAGE_CHUNKS = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ecc_en,
    input  logic                               ecc_clr,
    input  logic                               byte_vld,
    input  logic [7:0]                         byte_data,
    output logic                               chunk_done,
    output logic [$clog2(PAGE_CHUNKS)-1:0]     chunk_num,
    output logic [6+2*$clog2(CHUNK_BYTES)-1:0] par_raw,
    output logic [STORE_W-1:0]                 spare_bytes
);
    localparam int IDX_W = $clog2(CHUNK_BYTES);
    localparam int CH_W  = $clog2(PAGE_CHUNKS);
    localparam int RAW_W = COL_W + 2*IDX_W;

    typedef struct packed {
        logic [RAW_W-1:0] acc;
        logic [IDX_W-1:0] bidx;
        logic [CH_W-1:0]  cidx;
        logic             full;
        logic             done;
        logic [RAW_W-1:0] res;
        logic [CH_W-1:0]  res_ch;
    } st_t;

    st_t st_d, st_q;

    logic [2*IDX_W-1:0] line_c;
    logic [RAW_W-1:0]   contrib;
    logic               take;

    hecc_line_contrib #(.IDX_W(IDX_W)) line_i (
        .data (byte_data),
        .idx  (st_q.bidx),
        .line (line_c)
    );

    assign contrib = {line_c, col_bits(byte_data)};
    assign take    = byte_vld & ecc_en & ~st_q.full;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (ecc_clr) begin
            st_d.acc  = '0;
            st_d.bidx = '0;
            st_d.cidx = '0;
            st_d.full = 1'b0;
        end else if (take) begin
            if (&st_q.bidx) begin
                st_d.res    = st_q.acc ^ contrib;
                st_d.res_ch = st_q.cidx;
                st_d.done   = 1'b1;
                st_d.acc    = '0;
                st_d.bidx   = '0;
                st_d.cidx   = st_q.cidx + 1'b1;
                st_d.full   = &st_q.cidx;
            end else begin
                st_d.acc  = st_q.acc ^ contrib;
                st_d.bidx = st_q.bidx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chunk_done = st_q.done;
    assign chunk_num  = st_q.res_ch;
    assign par_raw    = st_q.res;

    hecc_spare_pack #(.RAW_W(RAW_W)) pack_i (
        .raw   (st_q.res),
        .spare (spare_bytes)
    );
endmodule

// File: rtl/hecc_chunk_acc_chk.sv
module hecc_chunk_acc_chk #(
    parameter int CHUNK_BYTES = 256,
    parameter int PAGE_CHUNKS = 16
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               ecc_en,
    input logic                               ecc_clr,
    input logic                               chunk_done,
    input logic [$clog2(PAGE_CHUNKS)-1:0]     chunk_num,
    input logic [6+2*$clog2(CHUNK_BYTES)-1:0] par_raw
);
    localparam int CH_W = $clog2(PAGE_CHUNKS);

    logic [CH_W:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen <= '0;
        else if (ecc_clr)    seen <= '0;
        else if (chunk_done) seen <= seen + 1'b1;
    end

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done |=> !chunk_done);

    a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !chunk_done |-> $stable(par_raw));

    a_r7_disabled_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en |=> !chunk_done);

    a_r8_clear_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |=> !chunk_done);

    a_r9_page_limit: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done |-> (seen < (CH_W+1)'(PAGE_CHUNKS)));

    a_r10_chunk_index: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done |-> (chunk_num == seen[CH_W-1:0]));
endmodule

bind hecc_chunk_acc hecc_chunk_acc_chk #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .PAGE_CHUNKS(PAGE_CHUNKS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ecc_en     (ecc_en),
    .ecc_clr    (ecc_clr),
    .chunk_done (chunk_done),
    .chunk_num  (chunk_num),
    .par_raw    (par_raw)
);

// File: tb/hecc_chunk_acc_tb_top.sv
module hecc_chunk_acc_tb_top;
    localparam int CB    = 16;
    localparam int PC    = 4;
    localparam int IDX_W = 4;
    localparam int RAW_W = 6 + 2*IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ecc_en = 1'b0;
    logic             ecc_clr = 1'b0;
    logic             byte_vld = 1'b0;
    logic [7:0]       byte_data = '0;
    logic             chunk_done;
    logic [1:0]       chunk_num;
    logic [RAW_W-1:0] par_raw;
    logic [23:0]      spare_bytes;

    always #4 clk = ~clk;

    hecc_chunk_acc #(.CHUNK_BYTES(CB), .PAGE_CHUNKS(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
        .byte_vld(byte_vld), .byte_data(byte_data), .chunk_done(chunk_done),
        .chunk_num(chunk_num), .par_raw(par_raw), .spare_bytes(spare_bytes)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0]       pat [CB];
    int               done_cnt = 0;
    logic [RAW_W-1:0] cap_raw [8];
    logic [1:0]       cap_num [8];
    logic [23:0]      cap_spare [8];

    always @(negedge clk) begin
        if (chunk_done) begin
            if (done_cnt < 8) begin
                cap_raw[done_cnt]   = par_raw;
                cap_num[done_cnt]   = chunk_num;
                cap_spare[done_cnt] = spare_bytes;
            end
            done_cnt++;
        end
    end

    // stimulus table: {mode, seed}
    localparam logic [15:0] VEC [6] = '{
        16'h0000, 16'h00FF, 16'h0153, 16'h0207, 16'h035A, 16'h0400
    };

    function automatic logic [7:0] gen(input logic [7:0] mode, input logic [7:0] seed, input int i);
        logic [7:0] v;
        case (mode)
            8'd0: v = seed;
            8'd1: v = (i == int'(seed[7:4])) ? (8'd1 << seed[2:0]) : 8'd0;
            8'd2: v = seed + 8'(i);
            8'd3: v = (seed ^ 8'(i*37)) + 8'(i*i);
            default: v = i[0] ? 8'h55 : 8'hAA;
        endcase
        return v;
    endfunction

    function automatic logic [RAW_W-1:0] model();
        logic [5:0]       col = '0;
        logic [2*IDX_W-1:0] line = '0;
        for (int i = 0; i < CB; i++) begin
            for (int b = 0; b < 8; b++)
                if (pat[i][b])
                    for (int k = 0; k < 3; k++)
                        col[2*k + (b >> k) % 2] ^= 1'b1;
            for (int j = 0; j < IDX_W; j++)
                line[2*j + (i >> j) % 2] ^= ^pat[i];
        end
        return {line, col};
    endfunction

    function automatic logic [23:0] spare_of(input logic [RAW_W-1:0] r);
        logic [23:0] s;
        s = ~(24'(r) << 2);
        return {s[7:0], s[15:8], s[23:16]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic en);
        @(negedge clk);
        byte_vld = 1'b1; byte_data = d; ecc_en = en;
    endtask

    task automatic idle();
        @(negedge clk);
        byte_vld = 1'b0; ecc_en = 1'b1; ecc_clr = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        byte_vld = 1'b0; ecc_clr = 1'b1;
        @(negedge clk);
        ecc_clr = 1'b0;
        done_cnt = 0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [RAW_W-1:0] e0, e1, keep;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", 32'(chunk_done), 0);
        check("R1 raw", 32'(par_raw), 0);
        check("R1 num", 32'(chunk_num), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 spare", spare_bytes, 24'hFFFFFF);

        // table walk: R2 R3 R4 R6 R10
        for (int v = 0; v < 6; v++) begin
            clear();
            for (int i = 0; i < CB; i++) pat[i] = gen(VEC[v][15:8], VEC[v][7:0], i);
            e0 = model();
            for (int i = 0; i < CB; i++) put(pat[i], 1'b1);
            idle();
            check("R4 done pulse", 32'(chunk_done), 1);
            check("R2 R3 parity", 32'(par_raw), 32'(e0));
            check("R6 spare", spare_bytes, spare_of(e0));
            check("R10 num", 32'(chunk_num), 0);
            idle();
            check("R4 one cycle", 32'(chunk_done), 0);
            check("R4 hold", 32'(par_raw), 32'(e0));
        end

        // R5 back-to-back chunks
        clear();
        for (int i = 0; i < CB; i++) pat[i] = gen(8'd3, 8'h21, i);
        e0 = model();
        for (int i = 0; i < CB; i++) put(pat[i], 1'b1);
        for (int i = 0; i < CB; i++) pat[i] = gen(8'd2, 8'h90, i);
        e1 = model();
        for (int i = 0; i < CB; i++) put(pat[i], 1'b1);
        idle(); idle();
        check("R5 count", done_cnt, 2);
        check("R5 chunk0", 32'(cap_raw[0]), 32'(e0));
        check("R5 chunk1", 32'(cap_raw[1]), 32'(e1));
        check("R10 idx1", 32'(cap_num[1]), 1);

        // R7 disabled bytes ignored
        clear();
        for (int i = 0; i < CB; i++) pat[i] = gen(8'd3, 8'h6C, i);
        e0 = model();
        for (int i = 0; i < 7; i++) put(pat[i], 1'b1);
        for (int i = 0; i < 5; i++) put(8'hC3 + 8'(i), 1'b0);
        for (int i = 7; i < CB; i++) put(pat[i], 1'b1);
        idle(); idle();
        check("R7 one done", done_cnt, 1);
        check("R7 parity", 32'(cap_raw[0]), 32'(e0));

        // R8 clear drops partial chunk, wins over same-cycle byte
        clear();
        for (int i = 0; i < 5; i++) put(8'h3F ^ 8'(i), 1'b1);
        keep = par_raw;
        @(negedge clk);
        byte_vld = 1'b1; byte_data = 8'hE7; ecc_clr = 1'b1;
        @(negedge clk);
        ecc_clr = 1'b0; byte_vld = 1'b0;
        check("R8 result kept", 32'(par_raw), 32'(keep));
        done_cnt = 0;
        for (int i = 0; i < CB; i++) pat[i] = gen(8'd1, 8'hB6, i);
        e0 = model();
        for (int i = 0; i < CB; i++) put(pat[i], 1'b1);
        idle(); idle();
        check("R8 one done", done_cnt, 1);
        check("R8 parity", 32'(cap_raw[0]), 32'(e0));
        check("R8 num reset", 32'(cap_num[0]), 0);

        // R9 page limit
        clear();
        for (int c = 0; c < PC; c++) begin
            for (int i = 0; i < CB; i++) pat[i] = gen(8'd2, 8'(c*16), i);
            if (c == PC-1) e0 = model();
            for (int i = 0; i < CB; i++) put(pat[i], 1'b1);
        end
        idle(); idle();
        check("R9 page dones", done_cnt, PC);
        check("R10 last idx", 32'(cap_num[PC-1]), PC-1);
        for (int i = 0; i < CB + 3; i++) put(8'h81 + 8'(i), 1'b1);
        idle(); idle();
        check("R9 oob ignored", done_cnt, PC);
        check("R9 raw held", 32'(par_raw), 32'(e0));
        clear();
        for (int i = 0; i < CB; i++) pat[i] = gen(8'd0, 8'h01, i);
        e0 = model();
        for (int i = 0; i < CB; i++) put(pat[i], 1'b1);
        idle(); idle();
        check("R9 restart", done_cnt, 1);
        check("R9 restart parity", 32'(cap_raw[0]), 32'(e0));
        check("R6 restart spare", cap_spare[0], spare_of(e0));

        report();
    end
endmodule